// File: doc/BRIEF.md
# Serial Flash Programming Host Sequencer

This block is the host side of a two-wire serial programming link. It drives a clock line and a data line (a driven value plus an output enable for an external tri-state pad) to write a run of 16-bit words into the code memory of a target that is already in programming mode. A single start request carries a 22-bit start address and a word count. The sequencer sends a pointer setup once, then streams the words through a valid/ready handshake. It closes every write-buffer region with a start-programming frame, followed by a trailing no-operation frame. On the fourth clock of that frame the clock is held high for the programming time and then held low for the discharge time.

Every frame is 20 clock periods long: a 4-bit command followed by a 16-bit payload. Both are sent least-significant bit first. Data changes as the clock rises and is stable while the clock is high, so the target samples it on the falling edge. The high and low times of the clock are runtime cycle counts, and so are the programming and discharge times. The buffer size in bytes is the parameter `BUF_BYTES`, with legal values 8, 16, 32 and 64. Regions are aligned to their own size.

The controller walks these states. IDLE goes to SETUP on an accepted start, or to DONE when the count is zero. SETUP goes to SETUP_WAIT when it issues a setup frame. SETUP_WAIT returns to SETUP, or goes to FETCH after the eighth frame. FETCH goes to DATA_WAIT when a word is accepted. DATA_WAIT goes back to FETCH after a load frame, or to NOP after a program frame. NOP goes to NOP_WAIT. NOP_WAIT goes to FETCH while words remain, or to DONE after the last word. DONE returns to IDLE. The frame shifter has three states: IDLE, HIGH (clock high) and LOW (clock low).

Top module: `flash_prog_seq`

## Requirements
- R1: Each frame is 20 clock periods: command bits 0..3 first, then payload bits 0..15, each LSB first. The data line changes only as the clock rises and holds its value while the clock is high.
- R2: Outside the held fourth clock of a trailing no-operation frame, every clock high phase lasts `cfg_clk_high` cycles and every low phase inside a frame lasts `cfg_clk_low` cycles. A value of 0 is treated as 1.
- R3: After a start, eight frames with command 0000 come first. Their payloads, in order, are 8EA6h, 9CA6h, 0E00h|addr[21:16], 6EF8h, 0E00h|addr[15:8], 6EF7h, 0E00h|addr[7:0] and 6EF6h.
- R4: Each word is sent as its payload in one frame, with the word address advancing by 2 per word from the start address with bit 0 cleared. The command is 1111 when the word is the last of its region (address mod `BUF_BYTES` equals `BUF_BYTES`-2) or the last word of the block. Otherwise it is 1101.
- R5: Every 1111 frame is followed by a frame with command 0000 and payload 0000h. In that frame the fourth clock is high for `cfg_prog_time` cycles and the following low phase lasts `cfg_disch_time` cycles.
- R6: The setup frames are sent only once per start. Later regions carry only load, program and no-operation frames.
- R7: `wr_ready` is high only while the sequencer waits for a word. The sequencer stalls there with the clock low for as long as `wr_valid` is low.
- R8: `busy` rises on the edge that accepts a start and falls when `done` pulses high for one cycle, after the last frame's final low phase. A start while busy has no effect on the frames sent.
- R9: A start with a word count of zero produces a `done` pulse on the next cycle, with no frame sent and `busy` staying low.
- R10: `pgd_oe` is high whenever the clock is high during a frame. Between runs, `pgd_oe`, `pgd_out` and `pgc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, one cycle |
| start_addr | input | 22 | Byte address of the first word (bit 0 ignored) |
| word_count | input | CNT_W | Number of 16-bit words to write |
| cfg_clk_high | input | PHASE_W | Clock high time in cycles |
| cfg_clk_low | input | PHASE_W | Clock low time in cycles |
| cfg_prog_time | input | TIME_W | Programming hold time in cycles |
| cfg_disch_time | input | TIME_W | Discharge low time in cycles |
| wr_data | input | 16 | Data word |
| wr_valid | input | 1 | Data word valid |
| wr_ready | output | 1 | Sequencer ready for a word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pgc | output | 1 | Programming clock to the target |
| pgd_out | output | 1 | Data value driven onto the data line |
| pgd_oe | output | 1 | Data line output enable |

## Verification
`busy` is due on the first edge after a start is sampled, so the bench checks it at the next falling system-clock edge. A zero-count `done` appears at that same point. Frame content and phase lengths have no fixed latency from the start request, because of the handshake stalls. The bench therefore rebuilds each frame from `pgc` transitions sampled on falling system-clock edges and counts the high and low cycles of every bit. For each run it waits for the `done` pulse and only then compares the collected frames, bit timings and end state against a list of expected frames computed from the address, count and data words.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;

    localparam int ADDR_W       = 22;
    localparam int CMD_W        = 4;
    localparam int PAYLOAD_W    = 16;
    localparam int FRAME_BITS   = CMD_W + PAYLOAD_W;
    localparam int HOLD_BIT_POS = 3;
    localparam int SETUP_FRAMES = 8;
    localparam int SETUP_IDX_W  = $clog2(SETUP_FRAMES);

    localparam logic [CMD_W-1:0] CMD_CORE      = 4'b0000;
    localparam logic [CMD_W-1:0] CMD_LOAD_INC  = 4'b1101;
    localparam logic [CMD_W-1:0] CMD_LOAD_PROG = 4'b1111;

    typedef struct packed {
        logic [CMD_W-1:0]     cmd;
        logic [PAYLOAD_W-1:0] payload;
    } frame_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_HIGH,
        SH_LOW
    } sh_state_t;

    typedef enum logic [2:0] {
        C_IDLE,
        C_SETUP,
        C_SETUP_WAIT,
        C_FETCH,
        C_DATA_WAIT,
        C_NOP,
        C_NOP_WAIT,
        C_DONE
    } ctl_state_t;

    typedef enum logic [1:0] {
        SEL_SETUP,
        SEL_DATA,
        SEL_NOP
    } fsel_t;

    // Core-instruction payload for setup step idx, pointing at addr.
    function automatic logic [PAYLOAD_W-1:0] setup_word(
        input logic [SETUP_IDX_W-1:0] idx,
        input logic [ADDR_W-1:0]      addr
    );
        logic [PAYLOAD_W-1:0] w;
        unique case (idx)
            3'd0:    w = 16'h8EA6;
            3'd1:    w = 16'h9CA6;
            3'd2:    w = {8'h0E, 2'b00, addr[21:16]};
            3'd3:    w = 16'h6EF8;
            3'd4:    w = {8'h0E, addr[15:8]};
            3'd5:    w = 16'h6EF7;
            3'd6:    w = {8'h0E, addr[7:0]};
            default: w = 16'h6EF6;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pgm_frame_shifter.sv
module pgm_frame_shifter
    import pgm_seq_pkg::*;
#(
    parameter int PHASE_W = 8,
    parameter int TIME_W  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  frame_t             frame_in,
    input  logic               hold_fourth,
    input  logic [PHASE_W-1:0] t_high,
    input  logic [PHASE_W-1:0] t_low,
    input  logic [TIME_W-1:0]  t_prog,
    input  logic [TIME_W-1:0]  t_disch,
    output logic               idle,
    output logic               frame_done,
    output logic               pgc,
    output logic               pgd,
    output logic               pgd_oe
);

    localparam int BIT_IDX_W = $clog2(FRAME_BITS);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(FRAME_BITS - 1);
    localparam logic [BIT_IDX_W-1:0] HOLD_BIT = BIT_IDX_W'(HOLD_BIT_POS);

    sh_state_t              st, st_n;
    logic [FRAME_BITS-1:0]  sr;
    logic [BIT_IDX_W-1:0]   bit_idx;
    logic [BIT_IDX_W-1:0]   nxt_idx;
    logic [TIME_W-1:0]      cnt;
    logic                   long_q;
    logic [TIME_W-1:0]      hi_next;
    logic [TIME_W-1:0]      lo_now;
    logic                   cnt_zero;

    function automatic logic [TIME_W-1:0] span_m1(input logic [TIME_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction

    assign nxt_idx  = bit_idx + 1'b1;
    assign cnt_zero = (cnt == '0);
    assign hi_next  = (long_q && nxt_idx == HOLD_BIT) ? t_prog  : TIME_W'(t_high);
    assign lo_now   = (long_q && bit_idx == HOLD_BIT) ? t_disch : TIME_W'(t_low);

    // Next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            SH_IDLE: if (load)     st_n = SH_HIGH;
            SH_HIGH: if (cnt_zero) st_n = SH_LOW;
            SH_LOW:  if (cnt_zero) st_n = (bit_idx == LAST_BIT) ? SH_IDLE : SH_HIGH;
            default: st_n = SH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SH_IDLE;
        else        st <= st_n;
    end

    // Shift register, bit index and phase timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr      <= '0;
            bit_idx <= '0;
            cnt     <= '0;
            long_q  <= 1'b0;
        end else begin
            unique case (st)
                SH_IDLE: begin
                    if (load) begin
                        sr      <= {frame_in.payload, frame_in.cmd};
                        bit_idx <= '0;
                        long_q  <= hold_fourth;
                        cnt     <= span_m1(TIME_W'(t_high));
                    end
                end
                SH_HIGH: begin
                    if (cnt_zero) cnt <= span_m1(lo_now);
                    else          cnt <= cnt - 1'b1;
                end
                SH_LOW: begin
                    if (cnt_zero) begin
                        if (bit_idx != LAST_BIT) begin
                            sr      <= sr >> 1;
                            bit_idx <= nxt_idx;
                            cnt     <= span_m1(hi_next);
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        idle       = (st == SH_IDLE);
        pgc        = (st == SH_HIGH);
        pgd_oe     = (st != SH_IDLE);
        pgd        = pgd_oe & sr[0];
        frame_done = (st == SH_LOW) && cnt_zero && (bit_idx == LAST_BIT);
    end

    // R1
    pgd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pgc && $past(pgc)) |-> $stable(pgd));

    // R10
    oe_during_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgc |-> pgd_oe);

    // R1
    load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> idle);

endmodule

// File: rtl/pgm_addr_track.sv
module pgm_addr_track
    import pgm_seq_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BUF_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [CNT_W-1:0]  init_cnt,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              region_end,
    output logic              final_word
);

    localparam int REGION_W = $clog2(BUF_BYTES);

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr      <= '0;
            remaining <= '0;
        end else if (init) begin
            addr      <= {init_addr[ADDR_W-1:1], 1'b0};
            remaining <= init_cnt;
        end else if (step) begin
            addr      <= addr + ADDR_W'(2);
            remaining <= remaining - 1'b1;
        end
    end

    assign region_end = &addr[REGION_W-1:1];
    assign final_word = (remaining == CNT_W'(1));

    // R4
    step_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (remaining != '0));

endmodule

// File: rtl/pgm_seq_ctrl.sv
module pgm_seq_ctrl
    import pgm_seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   cnt_zero,
    input  logic                   sh_idle,
    input  logic                   frame_done,
    input  logic                   region_end,
    input  logic                   final_word,
    input  logic                   wr_valid,
    output logic                   trk_init,
    output logic                   trk_step,
    output logic                   frame_load,
    output fsel_t                  frame_sel,
    output logic                   prog_frame,
    output logic [SETUP_IDX_W-1:0] setup_idx,
    output logic                   busy,
    output logic                   done,
    output logic                   wr_ready
);

    localparam logic [SETUP_IDX_W-1:0] SETUP_LAST = SETUP_IDX_W'(SETUP_FRAMES - 1);

    ctl_state_t st, st_n;
    logic       prog_q;
    logic       last_q;

    // Next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            C_IDLE:       if (start) st_n = cnt_zero ? C_DONE : C_SETUP;
            C_SETUP:      if (sh_idle) st_n = C_SETUP_WAIT;
            C_SETUP_WAIT: if (frame_done) st_n = (setup_idx == SETUP_LAST) ? C_FETCH : C_SETUP;
            C_FETCH:      if (wr_valid) st_n = C_DATA_WAIT;
            C_DATA_WAIT:  if (frame_done) st_n = prog_q ? C_NOP : C_FETCH;
            C_NOP:        if (sh_idle) st_n = C_NOP_WAIT;
            C_NOP_WAIT:   if (frame_done) st_n = last_q ? C_DONE : C_FETCH;
            C_DONE:       st_n = C_IDLE;
            default:      st_n = C_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= st_n;
    end

    // Setup index and per-word flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_idx <= '0;
            prog_q    <= 1'b0;
            last_q    <= 1'b0;
        end else begin
            if (st == C_IDLE)
                setup_idx <= '0;
            else if (st == C_SETUP_WAIT && frame_done)
                setup_idx <= setup_idx + 1'b1;
            if (st == C_FETCH && wr_valid) begin
                prog_q <= region_end || final_word;
                last_q <= final_word;
            end
        end
    end

    // Outputs
    always_comb begin
        trk_init   = 1'b0;
        trk_step   = 1'b0;
        frame_load = 1'b0;
        frame_sel  = SEL_SETUP;
        prog_frame = region_end || final_word;
        busy       = 1'b1;
        done       = 1'b0;
        wr_ready   = 1'b0;
        unique case (st)
            C_IDLE: begin
                busy     = 1'b0;
                trk_init = start;
            end
            C_SETUP:      frame_load = sh_idle;
            C_SETUP_WAIT: ;
            C_FETCH: begin
                wr_ready   = 1'b1;
                frame_sel  = SEL_DATA;
                frame_load = wr_valid;
            end
            C_DATA_WAIT:  trk_step = frame_done;
            C_NOP: begin
                frame_sel  = SEL_NOP;
                frame_load = sh_idle;
            end
            C_NOP_WAIT:   ;
            C_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default:      busy = 1'b0;
        endcase
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import pgm_seq_pkg::*;
#(
    parameter int BUF_BYTES = 8,
    parameter int CNT_W     = 16,
    parameter int PHASE_W   = 8,
    parameter int TIME_W    = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [21:0]        start_addr,
    input  logic [CNT_W-1:0]   word_count,
    input  logic [PHASE_W-1:0] cfg_clk_high,
    input  logic [PHASE_W-1:0] cfg_clk_low,
    input  logic [TIME_W-1:0]  cfg_prog_time,
    input  logic [TIME_W-1:0]  cfg_disch_time,
    input  logic [15:0]        wr_data,
    input  logic               wr_valid,
    output logic               wr_ready,
    output logic               busy,
    output logic               done,
    output logic               pgc,
    output logic               pgd_out,
    output logic               pgd_oe
);

    logic                   trk_init, trk_step;
    logic [ADDR_W-1:0]      trk_addr;
    logic                   region_end, final_word;
    logic                   frame_load, prog_frame;
    fsel_t                  frame_sel;
    logic [SETUP_IDX_W-1:0] setup_idx;
    logic                   sh_idle, frame_done;
    frame_t                 frame_mux;

    pgm_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cnt_zero   (word_count == '0),
        .sh_idle    (sh_idle),
        .frame_done (frame_done),
        .region_end (region_end),
        .final_word (final_word),
        .wr_valid   (wr_valid),
        .trk_init   (trk_init),
        .trk_step   (trk_step),
        .frame_load (frame_load),
        .frame_sel  (frame_sel),
        .prog_frame (prog_frame),
        .setup_idx  (setup_idx),
        .busy       (busy),
        .done       (done),
        .wr_ready   (wr_ready)
    );

    pgm_addr_track #(
        .CNT_W     (CNT_W),
        .BUF_BYTES (BUF_BYTES)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (trk_init),
        .init_addr  (start_addr),
        .init_cnt   (word_count),
        .step       (trk_step),
        .addr       (trk_addr),
        .region_end (region_end),
        .final_word (final_word)
    );

    // Frame content selection
    always_comb begin
        unique case (frame_sel)
            SEL_SETUP: begin
                frame_mux.cmd     = CMD_CORE;
                frame_mux.payload = setup_word(setup_idx, trk_addr);
            end
            SEL_DATA: begin
                frame_mux.cmd     = prog_frame ? CMD_LOAD_PROG : CMD_LOAD_INC;
                frame_mux.payload = wr_data;
            end
            default: begin
                frame_mux.cmd     = CMD_CORE;
                frame_mux.payload = '0;
            end
        endcase
    end

    pgm_frame_shifter #(
        .PHASE_W (PHASE_W),
        .TIME_W  (TIME_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (frame_load),
        .frame_in    (frame_mux),
        .hold_fourth (frame_sel == SEL_NOP),
        .t_high      (cfg_clk_high),
        .t_low       (cfg_clk_low),
        .t_prog      (cfg_prog_time),
        .t_disch     (cfg_disch_time),
        .idle        (sh_idle),
        .frame_done  (frame_done),
        .pgc         (pgc),
        .pgd         (pgd_out),
        .pgd_oe      (pgd_oe)
    );

    // R7
    stall_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !pgc);

    // R9
    idle_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pgc);

endmodule

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;

    localparam int BUF_BYTES = 8;
    localparam int CNT_W     = 16;
    localparam int PHASE_W   = 8;
    localparam int TIME_W    = 20;
    localparam int MAXF      = 256;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [21:0]        start_addr = '0;
    logic [CNT_W-1:0]   word_count = '0;
    logic [PHASE_W-1:0] cfg_clk_high = 8'd1;
    logic [PHASE_W-1:0] cfg_clk_low = 8'd1;
    logic [TIME_W-1:0]  cfg_prog_time = 20'd1;
    logic [TIME_W-1:0]  cfg_disch_time = 20'd1;
    logic [15:0]        wr_data = '0;
    logic               wr_valid = 1'b0;
    logic               wr_ready, busy, done, pgc, pgd_out, pgd_oe;

    flash_prog_seq #(
        .BUF_BYTES (BUF_BYTES), .CNT_W (CNT_W), .PHASE_W (PHASE_W), .TIME_W (TIME_W)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start (start), .start_addr (start_addr),
        .word_count (word_count), .cfg_clk_high (cfg_clk_high), .cfg_clk_low (cfg_clk_low),
        .cfg_prog_time (cfg_prog_time), .cfg_disch_time (cfg_disch_time),
        .wr_data (wr_data), .wr_valid (wr_valid), .wr_ready (wr_ready),
        .busy (busy), .done (done), .pgc (pgc), .pgd_out (pgd_out), .pgd_oe (pgd_oe)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [19:0] exp_frm [MAXF];
    logic [19:0] cap_frm [MAXF];
    int          exp_n = 0;
    int          cap_n = 0;
    logic [15:0] words [64];

    // Monitor state
    int          m_th = 1, m_tl = 1, m_p9 = 1, m_p10 = 1;
    int          mon_pos = 0, hcnt = 0, lcnt = 0;
    logic        prev_pgc = 1'b0, cur_bit = 1'b0;
    logic [19:0] fbits = '0;
    int          hi_len [20];
    int          lo_len [20];
    int          tim_err = 0, long_err = 0, long_frames = 0;
    int          stall_err = 0, oe_err = 0, done_cnt = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_frame();
        logic lng;
        lng = (cap_n > 0) && (cap_frm[cap_n-1][3:0] == 4'hF);
        if (lng) long_frames++;
        for (int b = 0; b < 20; b++) begin
            int eh;
            eh = (lng && b == 3) ? m_p9 : m_th;
            if (hi_len[b] != eh) begin
                if (lng && b == 3) long_err++; else tim_err++;
            end
        end
        for (int b = 0; b < 19; b++) begin
            int el;
            el = (lng && b == 3) ? m_p10 : m_tl;
            if (lo_len[b] != el) begin
                if (lng && b == 3) long_err++; else tim_err++;
            end
        end
        if (cap_n < MAXF) cap_frm[cap_n] = fbits;
        cap_n++;
    endtask

    // Target-side frame capture, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mon_pos  = 0;
            prev_pgc = 1'b0;
        end else begin
            if (done) done_cnt++;
            if (wr_ready && pgc) stall_err++;
            if (pgc && !pgd_oe) oe_err++;
            if (pgc) begin
                if (!prev_pgc) begin
                    if (mon_pos != 0) lo_len[mon_pos-1] = lcnt;
                    hcnt = 1;
                end else begin
                    hcnt++;
                end
                cur_bit = pgd_out;
            end else begin
                if (prev_pgc) begin
                    fbits[mon_pos] = cur_bit;
                    hi_len[mon_pos] = hcnt;
                    lcnt = 1;
                    mon_pos++;
                    if (mon_pos == 20) begin
                        push_frame();
                        mon_pos = 0;
                    end
                end else begin
                    lcnt++;
                end
            end
            prev_pgc = pgc;
        end
    end

    task automatic add_exp(input logic [3:0] cmd, input logic [15:0] pay);
        exp_frm[exp_n] = {pay, cmd};
        exp_n++;
    endtask

    // Expected frame list from R3, R4, R5, R6
    task automatic build_exp(input logic [21:0] a0, input int n);
        logic [21:0] a;
        logic [21:0] wa;
        logic        last;
        a = {a0[21:1], 1'b0};
        exp_n = 0;
        add_exp(4'h0, 16'h8EA6);
        add_exp(4'h0, 16'h9CA6);
        add_exp(4'h0, {8'h0E, 2'b00, a[21:16]});
        add_exp(4'h0, 16'h6EF8);
        add_exp(4'h0, {8'h0E, a[15:8]});
        add_exp(4'h0, 16'h6EF7);
        add_exp(4'h0, {8'h0E, a[7:0]});
        add_exp(4'h0, 16'h6EF6);
        for (int i = 0; i < n; i++) begin
            wa = a + 22'(2 * i);
            last = ((int'(wa) % BUF_BYTES) == BUF_BYTES - 2) || (i == n - 1);
            add_exp(last ? 4'hF : 4'hD, words[i]);
            if (last) add_exp(4'h0, 16'h0000);
        end
    endtask

    task automatic feed(input int n, input int maxgap);
        for (int i = 0; i < n; i++) begin
            int gap;
            gap = (maxgap > 0) ? int'($urandom % 32'(maxgap + 1)) : 0;
            repeat (gap) @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = words[i];
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
            wr_valid = 1'b0;
        end
    endtask

    task automatic run(input logic [21:0] addr, input int n, input int th, input int tl,
                       input int p9, input int p10, input int maxgap, input logic poke);
        int guard;
        int done_before;
        cfg_clk_high   = 8'(th);
        cfg_clk_low    = 8'(tl);
        cfg_prog_time  = 20'(p9);
        cfg_disch_time = 20'(p10);
        m_th  = (th == 0) ? 1 : th;
        m_tl  = (tl == 0) ? 1 : tl;
        m_p9  = (p9 == 0) ? 1 : p9;
        m_p10 = (p10 == 0) ? 1 : p10;
        for (int i = 0; i < 64; i++) words[i] = 16'($urandom);
        build_exp(addr, n);
        @(negedge clk);
        cap_n = 0; tim_err = 0; long_err = 0; long_frames = 0;
        stall_err = 0; oe_err = 0;
        done_before = done_cnt;
        start_addr = addr;
        word_count = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "busy after start", 32'(busy), 32'd1);
        repeat (4) @(negedge clk);
        chk("R7", "ready low during setup", 32'(wr_ready), 32'd0);
        fork
            feed(n, maxgap);
            begin
                if (poke) begin
                    repeat (30) @(negedge clk);
                    start_addr = ~addr;
                    word_count = CNT_W'(3);
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        join
        guard = 0;
        while (done_cnt == done_before && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk("R8", "single done pulse", 32'(done_cnt - done_before), 32'd1);
        chk("R8", "busy after done", 32'(busy), 32'd0);
        chk("R10", "idle pgd_oe/pgd_out/pgc", {29'd0, pgd_oe, pgd_out, pgc}, 32'd0);
        chk("R6", "frame count", 32'(cap_n), 32'(exp_n));
        for (int k = 0; k < exp_n && k < cap_n; k++) begin
            if (k < 8)
                chk("R1 R3", $sformatf("setup frame %0d", k), 32'(cap_frm[k]), 32'(exp_frm[k]));
            else if (exp_frm[k][3:0] == 4'h0)
                chk("R1 R5", $sformatf("nop frame %0d", k), 32'(cap_frm[k]), 32'(exp_frm[k]));
            else
                chk("R1 R4", $sformatf("data frame %0d", k), 32'(cap_frm[k]), 32'(exp_frm[k]));
        end
        chk("R2", "bit phase timing errors", 32'(tim_err), 32'd0);
        chk("R5", "hold/discharge timing errors", 32'(long_err), 32'd0);
        chk("R7", "clock high while waiting", 32'(stall_err), 32'd0);
        chk("R10", "clock high without enable", 32'(oe_err), 32'd0);
    endtask

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset busy/done", {30'd0, busy, done}, 32'd0);
        chk("R7", "reset wr_ready", 32'(wr_ready), 32'd0);
        chk("R10", "reset pgc/pgd_oe/pgd_out", {29'd0, pgc, pgd_oe, pgd_out}, 32'd0);

        // One aligned buffer
        run(22'h000000, 4, 1, 1, 20, 10, 0, 1'b0);
        // Three aligned buffers, stalls, start ignored while busy (R8)
        run(22'h012340, 12, 2, 1, 35, 12, 3, 1'b1);
        // Unaligned start, odd address bit ignored, zero phase clamp (R2, R4)
        run(22'h000107, 6, 0, 2, 15, 7, 1, 1'b0);
        // Region boundary at top of address space
        run(22'h3FFFF8, 5, 1, 2, 9, 4, 0, 1'b0);

        // R9: zero word count
        @(negedge clk);
        begin
            int cap_before;
            cap_before = cap_n;
            word_count = '0;
            start_addr = 22'h000040;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R9", "done on zero count", 32'(done), 32'd1);
            chk("R9", "busy stays low", 32'(busy), 32'd0);
            @(negedge clk);
            chk("R9", "done one cycle", 32'(done), 32'd0);
            repeat (20) @(negedge clk);
            chk("R9", "no frames on zero count", 32'(cap_n), 32'(cap_before));
        end

        // Random runs
        for (int t = 0; t < 5; t++) begin
            logic [21:0] ra;
            ra = 22'($urandom);
            run(ra, 1 + int'($urandom % 16), 1 + int'($urandom % 3), 1 + int'($urandom % 3),
                8 + int'($urandom % 40), 4 + int'($urandom % 20), int'($urandom % 4), 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule